// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Vector Unit

This block gathers sixteen interrupt lines into one processor interrupt and a vector number. It is built from two identical eight-input priority resolvers. The first (primary) resolver drives the processor interrupt. The second (secondary) resolver reports its winning request into input 2 of the primary. External line n feeds resolver n/8 at input n%8. Each resolver keeps a pending-request register, an in-service register and a trigger-mode register. Within a resolver, a lower input index always has the higher priority. A request qualifies when it is unmasked and ranks above every input that is in service.

The processor acknowledges with a one-cycle `inta` strobe. On that edge the block registers an 8-bit vector, marks the winners in service and clears their edge-captured requests. If the primary winner is the cascade input, the secondary resolver is acknowledged in the same cycle, and a missing winner on either side is reported as the spurious input 7. A `poll` strobe instead registers the number of the winning line. It clears both the request and the in-service bit of that line and does not mark it in service. Vector bases, masks, trigger modes and end-of-interrupt strobes arrive on plain inputs.

Top module: `pic_cascade_top`

## Requirements
- R1: After a lone rising edge on line n, an acknowledge yields `{base[7:3], n%8}`, where base is `base_m` for n<8 and `base_s` for n>=8.
- R2: Within a resolver, input 0 ranks highest and input 7 lowest. All secondary lines rank at primary position 2, between lines 1 and 3.
- R3: `int_out` is high exactly when the primary has an unmasked pending request ranking above all its in-service inputs. It is low after reset, and it drops after an acknowledge when nothing else qualifies.
- R4: While the secondary has a winner, the primary input 2 request is set on the next edge. That request stays pending even if the secondary winner later disappears.
- R5: An acknowledge whose primary winner is input 2 also acknowledges the secondary winner. The vector is then `{base_s[7:3], secondary input}`.
- R6: If the primary wins on input 2 while the secondary has no winner, the acknowledge vector is `{base_s[7:3], 3'd7}`.
- R7: An acknowledge with no primary winner yields `{base_m[7:3], 3'd7}` and changes no state.
- R8: Bits [2:0] of `base_m` and `base_s` never affect the vector.
- R9: A `trig_wr_m`/`trig_wr_s` strobe loads `trig_data`, where bit i set means input i is level-triggered. The primary keeps only bits under 0xF8 and the secondary only bits under 0xDE, so inputs 0-2 of the primary and 0 and 5 of the secondary stay edge-triggered. A level request follows the line and survives an acknowledge. An edge request is cleared by an acknowledge and needs a new rising edge to return.
- R10: A poll registers the primary winner index in `poll_result` and clears that input's request and in-service bits. With no winner it registers 7.
- R11: A poll whose primary winner is input 2 registers 8 plus the secondary winner and clears the secondary winner's request and in-service bits, along with the primary input 2 request. If the secondary has no winner, the poll registers 15.
- R12: An `eoi_m`/`eoi_s` strobe clears the highest-priority in-service bit of its resolver.
- R13: A line masked through `mask_in[n]` does not raise `int_out` but stays pending. Clearing the mask raises `int_out` without a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | External interrupt lines |
| mask_in | input | 16 | Per-line mask, 1 blocks the line |
| trig_wr_m | input | 1 | Load primary trigger-mode register |
| trig_wr_s | input | 1 | Load secondary trigger-mode register |
| trig_data | input | 8 | Trigger-mode value, 1 means level |
| base_m | input | 8 | Primary vector base (bits 7:3 used) |
| base_s | input | 8 | Secondary vector base (bits 7:3 used) |
| eoi_m | input | 1 | Non-specific end of interrupt, primary |
| eoi_s | input | 1 | Non-specific end of interrupt, secondary |
| inta | input | 1 | Acknowledge strobe |
| poll | input | 1 | Poll strobe (ignored when inta is high) |
| int_out | output | 1 | Processor interrupt request |
| vector | output | 8 | Vector registered on the last acknowledge |
| poll_result | output | 8 | Line number registered on the last poll |

## Verification
The bench builds the block with its default trigger write masks, 0xF8 and 0xDE. Writing all ones to both trigger registers therefore reaches level mode on primary input 3 and secondary input 1 (line 9). The same write shows that primary input 0 and secondary input 0 (line 8) stay edge-triggered. With those masks, the spurious secondary path is reached two ways: by masking a secondary line after it has cascaded, and by dropping a level line after its cascade request was captured.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int VEC_W      = 8;
  localparam int CELL_LINES = 8;
  localparam int SEL_W      = 3;
  localparam logic [SEL_W-1:0] CASCADE_PIN  = 3'd2;
  localparam logic [SEL_W-1:0] SPURIOUS_PIN = 3'd7;

  // vector = upper base bits joined with the input number
  function automatic logic [VEC_W-1:0] form_vector(input logic [VEC_W-1:0] base,
                                                   input logic [SEL_W-1:0] pin);
    return {base[VEC_W-1:SEL_W], pin};
  endfunction

  // poll code: cascade results carry 8 plus the secondary input
  function automatic logic [VEC_W-1:0] form_poll(input logic casc,
                                                 input logic [SEL_W-1:0] pin);
    return {{(VEC_W-SEL_W-1){1'b0}}, casc, pin};
  endfunction
endpackage

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int          LINES     = 8,
  parameter logic [7:0]  TRIG_MASK = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] casc_set,
  input  logic             trig_wr,
  input  logic [LINES-1:0] trig_data,
  input  logic             ack_stb,
  input  logic             poll_stb,
  input  logic             eoi_stb,
  output logic             win_valid,
  output logic [$clog2(LINES)-1:0] win_idx
);
  localparam int IW = $clog2(LINES);
  localparam int PW = IW + 1;
  localparam logic [PW-1:0] NONE = PW'(LINES);
  localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};

  function automatic logic [PW-1:0] first_set(input logic [LINES-1:0] v);
    logic [PW-1:0] r;
    r = NONE;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  logic [LINES-1:0] irr_q, isr_q, trig_q, prev_q;
  logic [PW-1:0]    req_pri, srv_pri;
  logic [LINES-1:0] win_oh, eoi_oh, rise, irr_base, irr_clr;
  logic             ack_hit, poll_hit;

  assign req_pri   = first_set(irr_q & ~mask);
  assign srv_pri   = first_set(isr_q);
  assign win_valid = (req_pri < srv_pri);
  assign win_idx   = req_pri[IW-1:0];
  assign win_oh    = win_valid ? (ONE << win_idx) : '0;
  assign ack_hit   = ack_stb & win_valid;
  assign poll_hit  = poll_stb & win_valid;
  assign eoi_oh    = (eoi_stb && srv_pri != NONE) ? (ONE << srv_pri[IW-1:0]) : '0;
  assign rise      = lines & ~prev_q;

  // level inputs follow the line; edge inputs hold until cleared
  assign irr_base = (trig_q & lines) | (~trig_q & (irr_q | rise)) | casc_set;
  assign irr_clr  = (ack_hit ? (win_oh & ~trig_q) : '0) | (poll_hit ? win_oh : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      trig_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lines;
      irr_q  <= irr_base & ~irr_clr;
      isr_q  <= (isr_q & ~eoi_oh & ~(poll_hit ? win_oh : '0)) | (ack_hit ? win_oh : '0);
      if (trig_wr) trig_q <= trig_data & TRIG_MASK[LINES-1:0];
    end
  end

  p_ack_marks_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> isr_q[$past(win_idx)]);

  p_edge_cleared_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !trig_q[win_idx]) |=> !irr_q[$past(win_idx)]);

  p_poll_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> (!irr_q[$past(win_idx)] && !isr_q[$past(win_idx)]));

  p_eoi_clears_top_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb && (|isr_q)) |=> !isr_q[$past(srv_pri[IW-1:0])]);
endmodule

// File: rtl/pic_ack_unit.sv
module pic_ack_unit
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inta,
  input  logic             poll,
  input  logic             m_valid,
  input  logic [SEL_W-1:0] m_idx,
  input  logic             s_valid,
  input  logic [SEL_W-1:0] s_idx,
  input  logic [VEC_W-1:0] base_m,
  input  logic [VEC_W-1:0] base_s,
  output logic             m_ack,
  output logic             s_ack,
  output logic             m_poll,
  output logic             s_poll,
  output logic [VEC_W-1:0] vector_q,
  output logic [VEC_W-1:0] poll_q
);
  logic             take_poll, m_casc;
  logic [SEL_W-1:0] s_pin;
  logic [VEC_W-1:0] ack_vec, poll_val;

  assign take_poll = poll & ~inta;
  assign m_casc    = m_valid && (m_idx == CASCADE_PIN);
  assign s_pin     = s_valid ? s_idx : SPURIOUS_PIN;
  assign m_ack     = inta;
  assign s_ack     = inta & m_casc;
  assign m_poll    = take_poll;
  assign s_poll    = take_poll & m_casc;

  always_comb begin
    if (!m_valid)    ack_vec = form_vector(base_m, SPURIOUS_PIN);
    else if (m_casc) ack_vec = form_vector(base_s, s_pin);
    else             ack_vec = form_vector(base_m, m_idx);
  end

  always_comb begin
    if (!m_valid)    poll_val = form_poll(1'b0, SPURIOUS_PIN);
    else if (m_casc) poll_val = form_poll(1'b1, s_pin);
    else             poll_val = form_poll(1'b0, m_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vector_q <= '0;
      poll_q   <= '0;
    end else begin
      if (inta)      vector_q <= ack_vec;
      if (take_poll) poll_q   <= poll_val;
    end
  end

  p_master_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !m_valid) |=> (vector_q[SEL_W-1:0] == SPURIOUS_PIN &&
                            vector_q[VEC_W-1:SEL_W] == $past(base_m[VEC_W-1:SEL_W])));

  p_poll_primary_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_poll && !m_casc) |=> (poll_q < 8));

  p_poll_cascade_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_poll && m_casc) |=> (poll_q >= 8 && poll_q < 16));
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
  import pic_pkg::*;
#(
  parameter logic [7:0] MASTER_TRIG_MASK = 8'hF8,
  parameter logic [7:0] SLAVE_TRIG_MASK  = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic [15:0] mask_in,
  input  logic        trig_wr_m,
  input  logic        trig_wr_s,
  input  logic [7:0]  trig_data,
  input  logic [7:0]  base_m,
  input  logic [7:0]  base_s,
  input  logic        eoi_m,
  input  logic        eoi_s,
  input  logic        inta,
  input  logic        poll,
  output logic        int_out,
  output logic [7:0]  vector,
  output logic [7:0]  poll_result
);
  localparam int NCELL = 2;
  localparam logic [CELL_LINES-1:0] CASC_BIT = {{(CELL_LINES-1){1'b0}}, 1'b1} << CASCADE_PIN;

  logic [NCELL-1:0] cell_valid, cell_ack, cell_poll, cell_eoi, cell_trig;
  logic [SEL_W-1:0] cell_idx  [NCELL];
  logic [CELL_LINES-1:0] cell_casc [NCELL];

  // secondary winner is captured as an edge on primary input 2
  assign cell_casc[0] = cell_valid[1] ? CASC_BIT : '0;
  assign cell_casc[1] = '0;
  assign cell_eoi     = {eoi_s, eoi_m};
  assign cell_trig    = {trig_wr_s, trig_wr_m};

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    localparam logic [7:0] TM = (c == 0) ? MASTER_TRIG_MASK : SLAVE_TRIG_MASK;
    pic_resolver #(.LINES(CELL_LINES), .TRIG_MASK(TM)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines     (irq_in[c*CELL_LINES +: CELL_LINES]),
      .mask      (mask_in[c*CELL_LINES +: CELL_LINES]),
      .casc_set  (cell_casc[c]),
      .trig_wr   (cell_trig[c]),
      .trig_data (trig_data),
      .ack_stb   (cell_ack[c]),
      .poll_stb  (cell_poll[c]),
      .eoi_stb   (cell_eoi[c]),
      .win_valid (cell_valid[c]),
      .win_idx   (cell_idx[c])
    );
  end

  pic_ack_unit u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .inta     (inta),
    .poll     (poll),
    .m_valid  (cell_valid[0]),
    .m_idx    (cell_idx[0]),
    .s_valid  (cell_valid[1]),
    .s_idx    (cell_idx[1]),
    .base_m   (base_m),
    .base_s   (base_s),
    .m_ack    (cell_ack[0]),
    .s_ack    (cell_ack[1]),
    .m_poll   (cell_poll[0]),
    .s_poll   (cell_poll[1]),
    .vector_q (vector),
    .poll_q   (poll_result)
  );

  assign int_out = cell_valid[0];

  p_cascade_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && cell_ack[1]) |-> (cell_idx[0] == CASCADE_PIN));

  p_vector_cascade_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && cell_valid[0] && cell_idx[0] == CASCADE_PIN && cell_valid[1])
      |=> (vector[SEL_W-1:0] == $past(cell_idx[1])));
endmodule

// File: tb/pic_cascade_top_test.sv
`timescale 1ns/1ps
module pic_cascade_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in, mask_in;
  logic        trig_wr_m, trig_wr_s;
  logic [7:0]  trig_data, base_m, base_s;
  logic        eoi_m, eoi_s, inta, poll;
  logic        int_out;
  logic [7:0]  vector, poll_result;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pic_cascade_top uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_in(mask_in),
    .trig_wr_m(trig_wr_m), .trig_wr_s(trig_wr_s), .trig_data(trig_data),
    .base_m(base_m), .base_s(base_s), .eoi_m(eoi_m), .eoi_s(eoi_s),
    .inta(inta), .poll(poll), .int_out(int_out), .vector(vector),
    .poll_result(poll_result)
  );

  // {line[3:0], expected vector} with base_m=0x08, base_s=0x70
  localparam logic [11:0] TBL [8] = '{12'h008, 12'h109, 12'h30B, 12'h70F,
                                     12'h870, 12'hA72, 12'hF77, 12'h277};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_ack();
    inta = 1'b1; step(1); inta = 1'b0;
  endtask

  task automatic do_poll();
    poll = 1'b1; step(1); poll = 1'b0;
  endtask

  task automatic do_eoi(input logic m, input logic s);
    eoi_m = m; eoi_s = s; step(1); eoi_m = 1'b0; eoi_s = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; mask_in = '0; trig_wr_m = 0; trig_wr_s = 0;
    trig_data = '0; base_m = 8'h08; base_s = 8'h70; eoi_m = 0; eoi_s = 0;
    inta = 0; poll = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R3 reset int_out", {7'd0, int_out}, 8'h00);
    chk("R3 reset vector", vector, 8'h00);
    chk("R10 reset poll", poll_result, 8'h00);

    // R1 / R5 / R6 table walk
    for (int k = 0; k < 8; k++) begin
      irq_in[TBL[k][11:8]] = 1'b1;
      step(3);
      chk("R3 raised", {7'd0, int_out}, 8'h01);
      do_ack();
      chk("R1 R5 R6 table vector", vector, TBL[k][7:0]);
      chk("R3 dropped after ack", {7'd0, int_out}, 8'h00);
      do_eoi(1, 1);
      irq_in = '0;
      step(2);
    end

    // R2 priority inside primary
    irq_in[5] = 1; irq_in[1] = 1; step(2);
    do_ack(); chk("R2 line1 over 5", vector, 8'h09);
    chk("R3 lower blocked by service", {7'd0, int_out}, 8'h00);
    do_eoi(1, 0);
    chk("R12 eoi reopens", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R2 then line5", vector, 8'h0D);
    do_eoi(1, 0); irq_in = '0; step(2);

    // R2 secondary ranks at position 2
    irq_in[12] = 1; irq_in[3] = 1; step(3);
    do_ack(); chk("R2 line12 over 3", vector, 8'h74);
    do_eoi(1, 1);
    do_ack(); chk("R2 then line3", vector, 8'h0B);
    do_eoi(1, 0); irq_in = '0; step(2);

    // R3 nesting
    irq_in[5] = 1; step(2); do_ack();
    irq_in[6] = 1; step(2);
    chk("R3 lower while 5 in service", {7'd0, int_out}, 8'h00);
    irq_in[1] = 1; step(2);
    chk("R3 higher nests", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R3 nested vector", vector, 8'h09);
    do_eoi(1, 0); do_eoi(1, 0);
    do_ack(); chk("R12 pending 6 after eoi", vector, 8'h0E);
    do_eoi(1, 0); irq_in = '0; step(2);

    // R13 mask
    mask_in[4] = 1; irq_in[4] = 1; step(2);
    chk("R13 masked silent", {7'd0, int_out}, 8'h00);
    mask_in[4] = 0; #1;
    chk("R13 unmask raises", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R13 vector", vector, 8'h0C);
    do_eoi(1, 0); irq_in = '0; step(2);

    // R8 base low bits
    base_m = 8'h2F; base_s = 8'h57;
    irq_in[0] = 1; step(2); do_ack();
    chk("R8 primary base", vector, 8'h28);
    do_eoi(1, 0); irq_in = '0; step(1);
    irq_in[9] = 1; step(3); do_ack();
    chk("R8 secondary base", vector, 8'h51);
    do_eoi(1, 1); irq_in = '0; step(2);
    base_m = 8'h08; base_s = 8'h70;

    // R7 nothing pending
    do_ack(); chk("R7 spurious primary", vector, 8'h0F);
    chk("R7 no interrupt", {7'd0, int_out}, 8'h00);

    // R4 / R6 secondary vanishes after cascade
    irq_in[9] = 1; step(3);
    mask_in[9] = 1; step(1);
    chk("R4 cascade held pending", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R6 spurious secondary", vector, 8'h77);
    do_eoi(1, 0);
    mask_in[9] = 0; step(2);
    do_ack(); chk("R4 line9 after unmask", vector, 8'h71);
    do_eoi(1, 1); irq_in = '0; step(2);

    // R9 trigger modes
    trig_data = 8'hFF; trig_wr_m = 1; trig_wr_s = 1; step(1);
    trig_wr_m = 0; trig_wr_s = 0;
    irq_in[3] = 1; step(2);
    do_ack(); chk("R9 level line3", vector, 8'h0B);
    do_eoi(1, 0);
    chk("R9 level survives ack", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R9 level again", vector, 8'h0B);
    do_eoi(1, 0); irq_in[3] = 0; step(1);
    chk("R9 level follows line", {7'd0, int_out}, 8'h00);
    irq_in[0] = 1; step(2); do_ack();
    chk("R9 line0 vector", vector, 8'h08);
    do_eoi(1, 0);
    chk("R9 line0 forced edge", {7'd0, int_out}, 8'h00);
    irq_in[0] = 0;
    irq_in[8] = 1; step(3); do_ack();
    chk("R9 line8 vector", vector, 8'h70);
    do_eoi(1, 1); step(2);
    chk("R9 line8 forced edge", {7'd0, int_out}, 8'h00);
    irq_in[8] = 0;
    irq_in[9] = 1; step(3); do_ack();
    chk("R9 line9 level vector", vector, 8'h71);
    do_eoi(1, 1); step(2);
    chk("R9 line9 level survives", {7'd0, int_out}, 8'h01);
    irq_in[9] = 0; step(2);
    do_ack(); chk("R6 cascade left after drop", vector, 8'h77);
    do_eoi(1, 0);
    trig_data = 8'h00; trig_wr_m = 1; trig_wr_s = 1; step(1);
    trig_wr_m = 0; trig_wr_s = 0; step(1);

    // R10 poll on primary
    irq_in[4] = 1; step(2); do_poll();
    chk("R10 poll line4", poll_result, 8'h04);
    chk("R10 poll clears request", {7'd0, int_out}, 8'h00);
    irq_in[6] = 1; step(2);
    chk("R10 poll sets no service", {7'd0, int_out}, 8'h01);
    do_poll(); chk("R10 poll line6", poll_result, 8'h06);
    irq_in = '0; step(1);
    do_poll(); chk("R10 poll none", poll_result, 8'h07);

    // R11 poll through cascade
    irq_in[11] = 1; step(3); do_poll();
    chk("R11 poll line11", poll_result, 8'h0B);
    step(2);
    chk("R11 cascade request cleared", {7'd0, int_out}, 8'h00);
    irq_in[10] = 1; step(3);
    mask_in[10] = 1; step(1);
    do_poll(); chk("R11 poll spurious secondary", poll_result, 8'h0F);
    mask_in[10] = 0; step(2);
    do_poll(); chk("R11 poll line10", poll_result, 8'h0A);
    irq_in = '0; step(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule